// File: doc/BRIEF.md
# PCM Highway Time-Slot Transmitter

This block puts one channel's voice sample onto a time-division multiplexed PCM highway. A frame-sync pulse marks the start of each frame. A slot number and a fine skew offset together choose where, counted in PCLK periods from that mark, the channel's bits go out. A sample is either compressed, taking one 8-bit slot, or linear, taking two slots back to back (16 bits). Samples arrive already encoded, so the block only places and serializes them.

The serial bit can be driven onto either of two highway data ports or onto both. Each port has an active-low output enable that is asserted only while that port carries the channel's bits, so that an external tri-state buffer can share the highway. The outputs can be launched from the rising or from the falling PCLK edge. This lets the transmitter meet the timing of highways that sample on either edge.

The frame length in PCLK periods is a design parameter. The frame counter runs freely from one sync pulse to the next and restarts whenever a new sync pulse arrives, even an early one. The sample is captured at frame sync, so the value on the sample input while a frame is under way does not disturb the bits being sent.

Top module: `pcm_slot_tx`

## Requirements
- R1: After reset, and until the first frame-sync pulse is sampled, both enables are high (inactive), both data outputs are 0, and nothing is transmitted.
- R2: The rising edge that samples `fsync` high is edge 0. With rising-edge launch, the first bit is driven on rising edge number 8*`timeSlot` + `clockSlot` + 1.
- R3: `clockSlot` (0..7) delays the start of the transmission by exactly that many PCLK periods relative to the slot boundary.
- R4: Bits go out MSB first, one per PCLK period. With `linearMode`=0 the 8 bits `txSample[7:0]` are sent. With `linearMode`=1 all 16 bits `txSample[15:0]` are sent across two consecutive slots.
- R5: `portSel` bit 0 routes the stream to port A and bit 1 to port B (3 = both, 0 = none). A selected port's enable is low for exactly the transmitted bits. An unselected port keeps its data value and its enable stays high.
- R6: With `fallEdge`=1, data and enables change on the falling PCLK edge that follows the rising edge on which they would change with `fallEdge`=0.
- R7: Outside a transmission, the data outputs hold the last bit sent and the enables are high.
- R8: The sample and the linear flag are captured on the edge that samples `fsync`. Changes to `txSample` later in the frame are not sent in that frame.
- R9: A frame-sync pulse that arrives before the frame has ended restarts slot counting from that pulse.
- R10: Without a new sync pulse, the frame counter wraps after the frame length (parameter `FRAME_CLKS`, default 193), and the held sample is sent again at the same position in the next frame.
- R11: A transmission that starts near the end of the frame and runs past the frame length still completes its full bit count, with the enable kept low throughout.
- R12: If 8*`timeSlot` + `clockSlot` is not less than `FRAME_CLKS`, nothing is ever transmitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Highway bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, marks slot 0 |
| txSample | input | 16 | Encoded sample (compressed uses bits 7:0) |
| linearMode | input | 1 | 1 = 16-bit linear sample, 0 = 8-bit compressed |
| portSel | input | 2 | Output port routing, bit 0 = A, bit 1 = B |
| fallEdge | input | 1 | 1 = launch outputs on falling PCLK edge |
| timeSlot | input | 7 | Assigned time slot number |
| clockSlot | input | 3 | Skew offset in PCLK periods |
| dxA | output | 1 | Serial data, port A |
| dxB | output | 1 | Serial data, port B |
| tscAN | output | 1 | Active-low output enable, port A |
| tscBN | output | 1 | Active-low output enable, port B |

## Verification
Each bit is due a fixed number of edges after the sync edge. With rising-edge launch, bit k of a transmission placed at position P is visible after rising edge P+1+k. With falling-edge launch it appears half a period later. The bench records the outputs a quarter period after every rising edge and again a quarter period before the next one. It then compares each recording with a window computed from the slot, offset, mode and sample, so a falling-edge launch appears one entry later in the early record and on time in the late record. Every scenario starts from reset and one sync pulse, so the edge numbering in each comparison is exact.

// File: rtl/pcm_slot_tx_pkg.sv
package pcm_slot_tx_pkg;

  // Strobes from the slot controller to the serializer datapath.
  typedef struct packed {
    logic loadHold;   // capture sample at frame sync
    logic startTx;    // first bit of a transmission
    logic shiftBit;   // advance to the next bit
    logic endTx;      // transmission finished, release enables
  } txStrobes_t;

endpackage

// File: rtl/pcm_slot_tx_ctrl.sv
module pcm_slot_tx_ctrl
  import pcm_slot_tx_pkg::*;
#(
  parameter int FRAME_CLKS = 193,
  parameter int SLOT_BITS  = 8,
  parameter int TS_W       = 7,
  parameter int CS_W       = 3
) (
  input  logic            pclk,
  input  logic            rstN,
  input  logic            fsync,
  input  logic [TS_W-1:0] timeSlot,
  input  logic [CS_W-1:0] clockSlot,
  input  logic            holdLinear,
  output txStrobes_t      strobes,
  output logic            synced
);

  localparam int CNT_W = $clog2(FRAME_CLKS);
  localparam int POS_W = TS_W + $clog2(SLOT_BITS) + 1;
  localparam int CMP_W = (CNT_W > POS_W) ? CNT_W : POS_W;
  localparam int LEN_W = $clog2(2 * SLOT_BITS);

  logic [CNT_W-1:0] frameCnt;
  logic             syncedR;
  logic             active;
  logic [LEN_W-1:0] bitsLeft;
  logic [LEN_W-1:0] bitsLen;
  logic [CMP_W-1:0] startPos;
  logic             frameHit;
  logic             lastBit;
  logic             startNow;

  // Absolute start position inside the frame, in PCLK periods.
  assign startPos = CMP_W'(timeSlot) * CMP_W'(SLOT_BITS) + CMP_W'(clockSlot);
  assign frameHit = syncedR && !fsync && (CMP_W'(frameCnt) == startPos);
  assign lastBit  = active && (bitsLeft == '0);
  assign startNow = frameHit && (!active || lastBit);
  assign bitsLen  = holdLinear ? LEN_W'(2 * SLOT_BITS - 1) : LEN_W'(SLOT_BITS - 1);

  assign strobes.loadHold = fsync;
  assign strobes.startTx  = startNow;
  assign strobes.shiftBit = active && !lastBit;
  assign strobes.endTx    = lastBit && !startNow;
  assign synced           = syncedR;

  // Frame position counter: restarts on sync, wraps at the frame length.
  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      syncedR  <= 1'b0;
    end else if (fsync) begin
      frameCnt <= '0;
      syncedR  <= 1'b1;
    end else if (syncedR) begin
      frameCnt <= (frameCnt == CNT_W'(FRAME_CLKS - 1)) ? '0 : frameCnt + 1'b1;
    end
  end

  // Bit counter for the running transmission.
  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      bitsLeft <= '0;
    end else if (startNow) begin
      active   <= 1'b1;
      bitsLeft <= bitsLen;
    end else if (active && !lastBit) begin
      bitsLeft <= bitsLeft - 1'b1;
    end else if (lastBit) begin
      active   <= 1'b0;
    end
  end

endmodule

// File: rtl/pcm_slot_tx_datapath.sv
module pcm_slot_tx_datapath
  import pcm_slot_tx_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int NPORTS    = 2
) (
  input  logic                   pclk,
  input  logic                   rstN,
  input  txStrobes_t             strobes,
  input  logic [2*SLOT_BITS-1:0] txSample,
  input  logic                   linearMode,
  input  logic [NPORTS-1:0]      portSel,
  input  logic                   fallEdge,
  output logic                   holdLinear,
  output logic [NPORTS-1:0]      dxOut,
  output logic [NPORTS-1:0]      enOutN
);

  localparam int SAMPLE_W = 2 * SLOT_BITS;

  logic [SAMPLE_W-1:0] holdReg;
  logic [SAMPLE_W-1:0] aligned;
  logic [SAMPLE_W-1:0] shReg;
  logic [NPORTS-1:0]   portLat;
  logic                txBit;

  // Compressed samples are left-aligned so the MSB is always the top bit.
  assign aligned = holdLinear ? holdReg : {holdReg[SLOT_BITS-1:0], {SLOT_BITS{1'b0}}};
  assign txBit   = strobes.startTx ? aligned[SAMPLE_W-1] : shReg[SAMPLE_W-1];

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      holdReg    <= '0;
      holdLinear <= 1'b0;
    end else if (strobes.loadHold) begin
      holdReg    <= txSample;
      holdLinear <= linearMode;
    end
  end

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      portLat <= '0;
    end else if (strobes.startTx) begin
      shReg   <= aligned << 1;
      portLat <= portSel;
    end else if (strobes.shiftBit) begin
      shReg   <= shReg << 1;
    end
  end

  // One output lane per port: rising-edge register plus falling-edge retime.
  for (genvar i = 0; i < NPORTS; i++) begin : g_lane
    logic riseDx, riseEnN, fallDx, fallEnN;

    always_ff @(posedge pclk or negedge rstN) begin
      if (!rstN) begin
        riseDx  <= 1'b0;
        riseEnN <= 1'b1;
      end else if (strobes.startTx) begin
        if (portSel[i]) begin
          riseDx  <= txBit;
          riseEnN <= 1'b0;
        end else begin
          riseEnN <= 1'b1;
        end
      end else if (strobes.shiftBit && portLat[i]) begin
        riseDx <= txBit;
      end else if (strobes.endTx) begin
        riseEnN <= 1'b1;
      end
    end

    always_ff @(negedge pclk or negedge rstN) begin
      if (!rstN) begin
        fallDx  <= 1'b0;
        fallEnN <= 1'b1;
      end else begin
        fallDx  <= riseDx;
        fallEnN <= riseEnN;
      end
    end

    assign dxOut[i]  = fallEdge ? fallDx  : riseDx;
    assign enOutN[i] = fallEdge ? fallEnN : riseEnN;
  end

endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
  import pcm_slot_tx_pkg::*;
#(
  parameter int FRAME_CLKS = 193,
  parameter int SLOT_BITS  = 8,
  parameter int TS_W       = 7,
  parameter int CS_W       = 3
) (
  input  logic                   pclk,
  input  logic                   rstN,
  input  logic                   fsync,
  input  logic [2*SLOT_BITS-1:0] txSample,
  input  logic                   linearMode,
  input  logic [1:0]             portSel,
  input  logic                   fallEdge,
  input  logic [TS_W-1:0]        timeSlot,
  input  logic [CS_W-1:0]        clockSlot,
  output logic                   dxA,
  output logic                   dxB,
  output logic                   tscAN,
  output logic                   tscBN
);

  localparam int NPORTS = 2;

  txStrobes_t        strobes;
  logic              synced;
  logic              holdLinear;
  logic [NPORTS-1:0] dxOut;
  logic [NPORTS-1:0] enOutN;

  pcm_slot_tx_ctrl #(
    .FRAME_CLKS(FRAME_CLKS), .SLOT_BITS(SLOT_BITS), .TS_W(TS_W), .CS_W(CS_W)
  ) u_ctrl (
    .pclk(pclk), .rstN(rstN), .fsync(fsync), .timeSlot(timeSlot),
    .clockSlot(clockSlot), .holdLinear(holdLinear), .strobes(strobes), .synced(synced)
  );

  pcm_slot_tx_datapath #(
    .SLOT_BITS(SLOT_BITS), .NPORTS(NPORTS)
  ) u_dp (
    .pclk(pclk), .rstN(rstN), .strobes(strobes), .txSample(txSample),
    .linearMode(linearMode), .portSel(portSel), .fallEdge(fallEdge),
    .holdLinear(holdLinear), .dxOut(dxOut), .enOutN(enOutN)
  );

  assign dxA   = dxOut[0];
  assign dxB   = dxOut[1];
  assign tscAN = enOutN[0];
  assign tscBN = enOutN[1];

endmodule

// File: rtl/pcm_slot_tx_chk.sv
module pcm_slot_tx_chk (
  input logic pclk,
  input logic rstN,
  input logic synced,
  input logic dxA,
  input logic dxB,
  input logic tscAN,
  input logic tscBN
);

  logic       anyLow;
  logic [9:0] lowRun;

  assign anyLow = !tscAN || !tscBN;

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else       lowRun <= anyLow ? lowRun + 1'b1 : '0;
  end

  // R1: no enable before the first frame sync
  a_r1_idle_until_sync: assert property (@(posedge pclk) disable iff (!rstN)
    !synced |-> (tscAN && tscBN));

  // R5: both ports active together carry the same bit
  a_r5_both_ports_match: assert property (@(posedge pclk) disable iff (!rstN)
    (!tscAN && !tscBN) |-> (dxA == dxB));

  // R7: idle data holds its value
  a_r7_hold_idle_a: assert property (@(posedge pclk) disable iff (!rstN)
    (tscAN && $past(tscAN)) |-> $stable(dxA));

  a_r7_hold_idle_b: assert property (@(posedge pclk) disable iff (!rstN)
    (tscBN && $past(tscBN)) |-> $stable(dxB));

  // R4: an enable burst spans whole slots
  a_r4_whole_slots: assert property (@(posedge pclk) disable iff (!rstN)
    (!anyLow && $past(anyLow)) |-> (lowRun != '0 && lowRun[2:0] == 3'd0));

endmodule

bind pcm_slot_tx pcm_slot_tx_chk u_chk (
  .pclk(pclk), .rstN(rstN), .synced(synced),
  .dxA(dxA), .dxB(dxB), .tscAN(tscAN), .tscBN(tscBN)
);

// File: tb/tb_pcm_slot_tx.sv
module tb_pcm_slot_tx;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 193;

  logic        pclk = 1'b0;
  logic        rstN = 1'b0;
  logic        fsync = 1'b0;
  logic [15:0] txSample = '0;
  logic        linearMode = 1'b0;
  logic [1:0]  portSel = 2'b00;
  logic        fallEdge = 1'b0;
  logic [6:0]  timeSlot = '0;
  logic [2:0]  clockSlot = '0;
  logic        dxA, dxB, tscAN, tscBN;

  int checks = 0;
  int fails  = 0;

  // [port][cycle] = {dx, enN}; early = T/4 after rising edge, late = 3T/4
  logic [1:0] smpE [0:1][0:511];
  logic [1:0] smpL [0:1][0:511];

  always #(CLK_PERIOD/2) pclk = ~pclk;

  pcm_slot_tx #(.FRAME_CLKS(FRAME)) dut (
    .pclk(pclk), .rstN(rstN), .fsync(fsync), .txSample(txSample),
    .linearMode(linearMode), .portSel(portSel), .fallEdge(fallEdge),
    .timeSlot(timeSlot), .clockSlot(clockSlot),
    .dxA(dxA), .dxB(dxB), .tscAN(tscAN), .tscBN(tscBN)
  );

  task automatic setup(input int slot, input int cs, input logic [1:0] ps,
                       input logic lin, input logic fe, input logic [15:0] smp);
    @(negedge pclk);
    rstN = 1'b0;
    timeSlot = 7'(slot); clockSlot = 3'(cs); portSel = ps;
    linearMode = lin; fallEdge = fe; txSample = smp;
    repeat (2) @(negedge pclk);
    rstN = 1'b1;
    @(negedge pclk);
  endtask

  task automatic frameSync();
    @(negedge pclk);
    fsync = 1'b1;
    @(negedge pclk);
    fsync = 1'b0;
  endtask

  task automatic capture(input int c0, input int c1);
    for (int c = c0; c <= c1; c++) begin
      @(posedge pclk);
      #(CLK_PERIOD/4);
      smpE[0][c] = {dxA, tscAN};
      smpE[1][c] = {dxB, tscBN};
      #(CLK_PERIOD/2);
      smpL[0][c] = {dxA, tscAN};
      smpL[1][c] = {dxB, tscBN};
    end
  endtask

  // Compare one port's record over [c0,c1] with a window starting at s.
  task automatic checkPort(input string tag, input int port, input bit late,
                           input int c0, input int c1, input int s, input int nb,
                           input logic [15:0] data, input bit sel, input logic prevDx);
    bit bad = 1'b0;
    for (int c = c0; c <= c1; c++) begin
      logic [1:0] got, exp;
      got = late ? smpL[port][c] : smpE[port][c];
      if (sel && c >= s && c < s + nb)  exp = {data[nb-1-(c-s)], 1'b0};
      else if (sel && c >= s + nb)      exp = {data[0], 1'b1};
      else                              exp = {prevDx, 1'b1};
      if (!bad && got !== exp) begin
        bad = 1'b1;
        $display("FAIL %s port %0d cycle %0d: got {dx,enN}=%b expected %b", tag, port, c, got, exp);
      end
    end
    checks++;
    if (bad) fails++;
  endtask

  task automatic test_reset();   // R1
    @(negedge pclk); rstN = 1'b0;
    #(CLK_PERIOD/4);
    checks++;
    if ({dxA, dxB, tscAN, tscBN} !== 4'b0011) begin
      fails++;
      $display("FAIL R1 reset state: got %b expected 0011", {dxA, dxB, tscAN, tscBN});
    end
    setup(0, 0, 2'b11, 1'b0, 1'b0, 16'h00FF);
    capture(1, 250);
    checkPort("R1 no tx before sync", 0, 0, 1, 250, 0, 8, 16'h0, 0, 1'b0);
    checkPort("R1 no tx before sync", 1, 0, 1, 250, 0, 8, 16'h0, 0, 1'b0);
  endtask

  task automatic test_slot_pos();   // R2, R5, R7
    setup(3, 0, 2'b01, 1'b0, 1'b0, 16'h12A5);
    frameSync(); capture(1, 60);
    checkPort("R2 slot 3 position, R7 hold", 0, 0, 1, 60, 25, 8, 16'h00A5, 1, 1'b0);
    checkPort("R5 unselected B quiet", 1, 0, 1, 60, 25, 8, 16'h0, 0, 1'b0);
  endtask

  task automatic test_clock_slot();   // R3
    setup(3, 5, 2'b10, 1'b0, 1'b0, 16'h003C);
    frameSync(); capture(1, 60);
    checkPort("R3 offset 5 on B", 1, 0, 1, 60, 30, 8, 16'h003C, 1, 1'b0);
    checkPort("R5 unselected A quiet", 0, 0, 1, 60, 30, 8, 16'h0, 0, 1'b0);
    setup(2, 7, 2'b01, 1'b0, 1'b0, 16'h0081);
    frameSync(); capture(1, 50);
    checkPort("R3 offset 7", 0, 0, 1, 50, 24, 8, 16'h0081, 1, 1'b0);
  endtask

  task automatic test_linear();   // R4, R5
    setup(10, 2, 2'b11, 1'b1, 1'b0, 16'hC3A5);
    frameSync(); capture(1, 120);
    checkPort("R4 linear 16 bits on A", 0, 0, 1, 120, 83, 16, 16'hC3A5, 1, 1'b0);
    checkPort("R5 both ports, B", 1, 0, 1, 120, 83, 16, 16'hC3A5, 1, 1'b0);
  endtask

  task automatic test_fall_edge();   // R6
    setup(1, 0, 2'b01, 1'b0, 1'b1, 16'h0096);
    frameSync(); capture(1, 40);
    checkPort("R6 falling launch, early sample", 0, 0, 1, 40, 10, 8, 16'h0096, 1, 1'b0);
    checkPort("R6 falling launch, late sample", 0, 1, 1, 40, 9, 8, 16'h0096, 1, 1'b0);
  endtask

  task automatic test_latch_wrap();   // R8, R10
    setup(5, 3, 2'b01, 1'b0, 1'b0, 16'h005A);
    frameSync(); capture(1, 10);
    txSample = 16'h00FF;
    capture(11, 300);
    checkPort("R8 sample held from sync", 0, 0, 1, 236, 44, 8, 16'h005A, 1, 1'b0);
    checkPort("R10 repeat after wrap", 0, 0, 237, 300, 237, 8, 16'h005A, 1, 1'b0);
  endtask

  task automatic test_early_sync();   // R9
    setup(5, 0, 2'b01, 1'b0, 1'b0, 16'h0011);
    frameSync(); capture(1, 12);
    txSample = 16'h0077;
    frameSync(); capture(1, 60);
    checkPort("R9 restart on early sync", 0, 0, 1, 60, 41, 8, 16'h0077, 1, 1'b0);
  endtask

  task automatic test_partial();   // R11
    setup(23, 7, 2'b01, 1'b0, 1'b0, 16'h00C5);
    frameSync(); capture(1, 205);
    checkPort("R11 full length past frame end", 0, 0, 1, 205, 192, 8, 16'h00C5, 1, 1'b0);
    setup(24, 0, 2'b01, 1'b0, 1'b0, 16'h00E7);
    frameSync(); capture(1, 210);
    checkPort("R11 last position in frame", 0, 0, 1, 210, 193, 8, 16'h00E7, 1, 1'b0);
  endtask

  task automatic test_out_of_range();   // R12, R5 none
    setup(24, 1, 2'b11, 1'b0, 1'b0, 16'h00FF);
    frameSync(); capture(1, 400);
    checkPort("R12 start beyond frame", 0, 0, 1, 400, 0, 8, 16'h0, 0, 1'b0);
    checkPort("R12 start beyond frame", 1, 0, 1, 400, 0, 8, 16'h0, 0, 1'b0);
    setup(2, 0, 2'b00, 1'b0, 1'b0, 16'h00FF);
    frameSync(); capture(1, 40);
    checkPort("R5 no port selected", 0, 0, 1, 40, 0, 8, 16'h0, 0, 1'b0);
    checkPort("R5 no port selected", 1, 0, 1, 40, 0, 8, 16'h0, 0, 1'b0);
  endtask

  initial begin
    test_reset();
    test_slot_pos();
    test_clock_slot();
    test_linear();
    test_fall_edge();
    test_latch_wrap();
    test_early_sync();
    test_partial();
    test_out_of_range();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule